// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block models a single-clock synchronous static RAM with a four-beat burst address generator and a flow-through read path. Address, write data and all control inputs are sampled on the rising clock edge. A burst starts when either of two start strobes is sampled. The processor-side strobe always opens a read. The cache-side strobe may write in the same cycle. After the start, a 2-bit step counter produces the following word addresses, and it moves forward only in cycles where the advance input is high.

The burst order comes from a level input: low selects linear stepping and high selects interleaved stepping. A board that leaves that pin unconnected should tie it high. Writes are masked per byte lane, and a global write stores every lane. Three chip-enable inputs must all be high when a burst starts for the device to be selected. A deselect removes the output enable in the next cycle, and while deselected the array ignores writes. The bidirectional data bus is presented as separate read and write ports plus a read-data output enable.

Top module: `sburst_sram`

## Requirements
- R1: A processor start strobe with all chip enables high loads `addr`. After that edge, `rd_data` shows the stored word at `addr` and `rd_oe` is 1, with no further register stage.
- R2: With `order_ilv`=0, beat k of a burst that starts at word s reads address {s[AW-1:2], (s[1:0]+k) mod 4}.
- R3: With `order_ilv`=1, beat k reads address {s[AW-1:2], s[1:0] XOR k}.
- R4: The beat count increases only on edges where `advance` is 1. With no strobe, no advance and no write, `rd_data` holds its value.
- R5: After four advances the burst returns to its starting word, and it keeps cycling through the same four words until a new start strobe arrives.
- R6: When both start strobes are sampled together, the processor strobe wins. The cycle is a read and all write controls are ignored.
- R7: Without a global write, lane g (bits 8g+7:8g) is written only when `lane_wr_en`=1 and `lane_sel[g]`=1. All other lanes keep their old contents.
- R8: `wr_all`=1 writes all lanes of the addressed word, whatever `lane_wr_en` and `lane_sel` hold.
- R9: A start strobe with any of `en_a`, `en_b`, `en_c` low deselects the device. `rd_oe` is 0 after that edge. Writes and advances are ignored until a start strobe arrives with all enables high.
- R10: A cache start strobe with write controls writes the word at `addr`. A write with no strobe during a burst writes the word at the current burst address, after any advance in that cycle. `rd_oe` is 0 after every write edge.
- R11: While `rst_n` is low and after its release, `rd_oe` is 0 until a selecting start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | External word address |
| proc_start | input | 1 | Processor-side burst start (read) |
| cache_start | input | 1 | Cache-side burst start (read or write) |
| advance | input | 1 | Step the burst counter |
| order_ilv | input | 1 | 0 = linear order, 1 = interleaved order |
| en_a | input | 1 | Chip enable, active high |
| en_b | input | 1 | Chip enable, active high |
| en_c | input | 1 | Chip enable, active high |
| lane_wr_en | input | 1 | Byte-write enable |
| lane_sel | input | LANES | Per-lane write selects |
| wr_all | input | 1 | Global write of all lanes |
| wr_data | input | LANES*LW | Write data |
| rd_data | output | LANES*LW | Flow-through read data |
| rd_oe | output | 1 | Read data output enable |

## Verification
The bench builds the block with AW=4, LANES=4 and LW=8, so the array holds 16 words. At that size every word can be filled and read back, and bursts can be run from all sixteen start addresses in both orders, six beats each, with a hold cycle inside the burst. That also covers the wrap and the keeping of the upper address bits at every group of four. Each of the 16 lane-select patterns is also tried with the byte-write enable on and off, and with and without the global write, against a mask computed in the bench.

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 8,
  localparam int DW    = LANES * LW,
  localparam int WORDS = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             proc_start,
  input  logic             cache_start,
  input  logic             advance,
  input  logic             order_ilv,
  input  logic             en_a,
  input  logic             en_b,
  input  logic             en_c,
  input  logic             lane_wr_en,
  input  logic [LANES-1:0] lane_sel,
  input  logic             wr_all,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             rd_oe
);

  logic          act_q, oe_q;
  logic [1:0]    base_q, cnt_q;
  logic [AW-3:0] hi_q;
  logic [AW-1:0] addr_q;

  wire any_start = proc_start | cache_start;
  wire chip_hit  = en_a & en_b & en_c;
  wire act_n     = any_start ? chip_hit : act_q;

  wire [1:0] cnt_n = (act_q && advance) ? cnt_q + 2'd1 : cnt_q;
  wire [1:0] lo_n  = order_ilv ? (base_q ^ cnt_n) : (base_q + cnt_n);
  wire [AW-1:0] acc_addr = any_start ? addr : {hi_q, lo_n};

  wire [LANES-1:0] lane_mask = wr_all ? {LANES{1'b1}} :
                               (lane_wr_en ? lane_sel : {LANES{1'b0}});
  wire [LANES-1:0] wr_mask   = (act_n && !proc_start) ? lane_mask : {LANES{1'b0}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      oe_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      hi_q   <= '0;
      addr_q <= '0;
    end else begin
      act_q  <= act_n;
      oe_q   <= act_n && (wr_mask == '0);
      addr_q <= acc_addr;
      if (any_start) begin
        base_q <= addr[1:0];
        hi_q   <= addr[AW-1:2];
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_n;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (wr_mask[g]) mem[acc_addr] <= wr_data[g*LW +: LW];
    end
    assign rd_data[g*LW +: LW] = mem[addr_q];
  end

  assign rd_oe = oe_q;

  // R9
  deselect_drops_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_start && !chip_hit) |=> !rd_oe);

  // R6
  proc_start_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_start && chip_hit) |=> rd_oe);

  // R10
  write_cycle_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_start && !proc_start && chip_hit && wr_all) |=> !rd_oe);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_start && !advance && !wr_all && !(lane_wr_en && |lane_sel)) |=> $stable(rd_data));

  // R11
  reset_oe_chk: assert property (@(posedge clk) !rst_n |=> !rd_oe);

endmodule

// File: tb/sburst_sram_tb.sv
`timescale 1ns/1ps
module sburst_sram_tb_top;
  localparam int AW = 4, LANES = 4, LW = 8, DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic proc_start = 0, cache_start = 0, advance = 0, order_ilv = 0;
  logic en_a = 1, en_b = 1, en_c = 1;
  logic lane_wr_en = 0, wr_all = 0;
  logic [LANES-1:0] lane_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_oe;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sburst_sram #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_start(proc_start),
    .cache_start(cache_start), .advance(advance), .order_ilv(order_ilv),
    .en_a(en_a), .en_b(en_b), .en_c(en_c), .lane_wr_en(lane_wr_en),
    .lane_sel(lane_sel), .wr_all(wr_all), .wr_data(wr_data),
    .rd_data(rd_data), .rd_oe(rd_oe));

  function automatic logic [DW-1:0] pat(input int a);
    return (32'(a) * 32'h01030507) ^ 32'h5A3C96E1;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    proc_start = 0; cache_start = 0; advance = 0;
    lane_wr_en = 0; lane_sel = '0; wr_all = 0;
    en_a = 1; en_b = 1; en_c = 1;
  endtask

  task automatic rd(input int a);
    idle(); proc_start = 1; addr = AW'(a); cyc(); idle();
  endtask

  task automatic wr_word(input int a, input logic [DW-1:0] d);
    idle(); cache_start = 1; addr = AW'(a); wr_all = 1; wr_data = d; cyc(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    chk("R11 oe in reset", DW'(rd_oe), 0);
    rst_n = 1; cyc();
    chk("R11 oe after reset", DW'(rd_oe), 0);

    for (int a = 0; a < 16; a++) begin
      wr_word(a, pat(a));
      chk("R10 oe after write", DW'(rd_oe), 0);
    end
    for (int a = 0; a < 16; a++) begin
      rd(a);
      chk("R1 oe", DW'(rd_oe), 1);
      chk("R1 data", rd_data, pat(a));
    end

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 16; s++) begin
        int b;
        order_ilv = m[0];
        rd(s);
        b = 0;
        chk("R1 burst beat0", rd_data, pat(s));
        for (int k = 1; k <= 6; k++) begin
          int ea;
          if (k == 3) advance = 0;
          else begin advance = 1; b++; end
          cyc();
          advance = 0;
          ea = m ? ((s & 12) | ((s & 3) ^ (b & 3))) : ((s & 12) | (((s & 3) + b) & 3));
          if (k == 3) chk("R4 hold", rd_data, pat(ea));
          else if (b >= 4) chk("R5 wrap", rd_data, pat(ea));
          else if (m == 1) chk("R3 interleave", rd_data, pat(ea));
          else chk("R2 linear", rd_data, pat(ea));
        end
      end
    end
    order_ilv = 0;

    idle(); proc_start = 1; cache_start = 1; addr = 5; wr_all = 1; wr_data = ~pat(5);
    cyc(); idle();
    chk("R6 oe", DW'(rd_oe), 1);
    chk("R6 data", rd_data, pat(5));
    rd(5);
    chk("R6 no write", rd_data, pat(5));

    for (int en = 0; en < 2; en++)
      for (int g = 0; g < 2; g++)
        for (int m = 0; m < 16; m++) begin
          logic [DW-1:0] nw, ex;
          logic [3:0] mk;
          nw = ~pat(9) ^ 32'h00FF00FF;
          wr_word(9, pat(9));
          idle(); cache_start = 1; addr = 9; lane_wr_en = en[0]; lane_sel = 4'(m);
          wr_all = g[0]; wr_data = nw;
          cyc(); idle();
          rd(9);
          mk = g ? 4'hF : (en ? 4'(m) : 4'h0);
          for (int l = 0; l < 4; l++)
            ex[l*8 +: 8] = mk[l] ? nw[l*8 +: 8] : pat(9) >> (l*8);
          if (g) chk("R8 global", rd_data, ex);
          else chk("R7 lanes", rd_data, ex);
        end

    idle(); cache_start = 1; addr = 12; wr_all = 1; wr_data = 32'h11112222;
    cyc();
    idle(); advance = 1; wr_all = 1; wr_data = 32'h33334444;
    cyc(); idle();
    chk("R10 burst write oe", DW'(rd_oe), 0);
    rd(13);
    chk("R10 burst write", rd_data, 32'h33334444);
    rd(12);
    chk("R10 start write", rd_data, 32'h11112222);

    for (int e = 0; e < 3; e++) begin
      rd(3);
      chk("R9 selected oe", DW'(rd_oe), 1);
      idle(); proc_start = 1; addr = 3;
      if (e == 0) en_a = 0; else if (e == 1) en_b = 0; else en_c = 0;
      cyc(); idle();
      chk("R9 deselect oe", DW'(rd_oe), 0);
      advance = 1; wr_all = 1; wr_data = 32'hDEADBEEF;
      cyc(); idle();
      chk("R9 still off", DW'(rd_oe), 0);
      rd(3);
      chk("R9 write blocked", rd_data, pat(3));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule